// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block sits beside an asynchronous SRAM-style port and listens to its access stream. The chip-enable, write-enable and address pins are brought into the local clock domain through a short flop chain. Every falling edge of chip enable is then classified as one access: a read if write enable is high at that moment, a write otherwise. A nonvolatile command is hidden inside ordinary read traffic. Five fixed reads in strict order form the prefix, and a sixth read selects the operation.

When a command is recognised, the block raises a single-cycle request, either `store_req_o` or `recall_req_o`, to the nonvolatile sequencer. It then returns to idle. One sixth address is held back for factory test and yields no request. Any write, any out-of-order read and any repeated read breaks the sequence. While the sequencer reports busy, accesses are ignored and the progress made so far is kept.

Top module: `nv_cmd_detect`

## Requirements
- R1: Reads of hex 0E38, 31C7, 03E0, 3C1F, 303F and then 0FC0 produce exactly one single-cycle `store_req_o` pulse, after which the detector is idle. A further 0FC0 read on its own produces nothing.
- R2: The same five-read prefix followed by a read of hex 0C63 produces exactly one single-cycle `recall_req_o` pulse. The two requests are never high together.
- R3: The prefix followed by hex 339C produces no request and returns the detector to idle.
- R4: Only address bits 13..0 are compared, so bit 14 may take any value on any step without changing the result.
- R5: An access is counted only on a high-to-low transition of the synchronised chip enable. An address change while chip enable stays low is not a new access.
- R6: A chip-enable fall with write enable low is a write, and it aborts any partial sequence, even when its address equals the next expected one.
- R7: A read whose address is not the next expected entry aborts the sequence. This includes a repeated read of the address just matched, as caused by chip-enable noise.
- R8: A mismatching read at hex 0E38 restarts the match as if it were the first prefix read, so the sequence continues from the second entry.
- R9: While `busy_i` is high, accesses have no effect: no request is raised and the progress of a partial sequence is kept.
- R10: After reset both requests are low. A request is high in the third clock cycle after the cycle in which chip enable falls at the pins, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable from the memory port, active low, asynchronous |
| we_ni | input | 1 | Write enable from the memory port, active low, asynchronous |
| addr_i | input | 15 | Address from the memory port, asynchronous |
| busy_i | input | 1 | Sequencer busy, synchronous to clk_i |
| store_req_o | output | 1 | One-cycle request to start a store |
| recall_req_o | output | 1 | One-cycle request to start a recall |

## Verification
The request is due three rising edges after chip enable falls at the pins. Two of those edges belong to the synchroniser, and the third is the registered request. The driver changes pins just after a rising edge and records the edge count when it lowers chip enable. It then queues the expected result for that count plus three, with "nothing" as a valid expectation. The monitor samples on falling edges and pops an entry only when its due count arrives. A request seen in any cycle with no entry due is reported as a failure, which covers both early pulses and pulses that last longer than one cycle.

// File: rtl/nv_cmd_pkg.sv
package nv_cmd_pkg;
  localparam int KEY_W      = 14;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  typedef logic [KEY_W-1:0]  key_t;
  typedef logic [STEP_W-1:0] step_t;

  localparam key_t KEY_STORE  = 14'h0FC0;
  localparam key_t KEY_RECALL = 14'h0C63;
  localparam key_t KEY_TEST   = 14'h339C;  // reserved: never a request

  function automatic key_t prefix_key(step_t idx);
    case (idx)
      3'd0:    prefix_key = 14'h0E38;
      3'd1:    prefix_key = 14'h31C7;
      3'd2:    prefix_key = 14'h03E0;
      3'd3:    prefix_key = 14'h3C1F;
      3'd4:    prefix_key = 14'h303F;
      default: prefix_key = '0;
    endcase
  endfunction
endpackage

// File: rtl/nv_sync.sv
module nv_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= RST_VAL;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nv_access_edge.sv
module nv_access_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ns_i,
  input  logic we_ns_i,
  output logic access_o,
  output logic is_read_o
);
  logic ce_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_prev_q <= 1'b1;
    else         ce_prev_q <= ce_ns_i;
  end

  assign access_o  = ce_prev_q & ~ce_ns_i;
  assign is_read_o = we_ns_i;

  // R5: a held-low enable never yields back-to-back accesses
  p_access_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_o |=> !access_o);
endmodule

// File: rtl/nv_seq_track.sv
module nv_seq_track
  import nv_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic access_i,
  input  logic is_read_i,
  input  key_t key_i,
  input  logic busy_i,
  output logic store_req_o,
  output logic recall_req_o
);
  step_t step_q, step_d;
  logic  store_d, recall_d;

  always_comb begin
    step_d   = step_q;
    store_d  = 1'b0;
    recall_d = 1'b0;
    if (access_i && !busy_i) begin
      if (!is_read_i) begin
        step_d = '0;
      end else if (step_q < step_t'(PREFIX_LEN) && key_i == prefix_key(step_q)) begin
        step_d = step_q + step_t'(1);
      end else if (step_q == step_t'(PREFIX_LEN) && key_i == KEY_STORE) begin
        store_d = 1'b1;
        step_d  = '0;
      end else if (step_q == step_t'(PREFIX_LEN) && key_i == KEY_RECALL) begin
        recall_d = 1'b1;
        step_d   = '0;
      end else if (key_i == prefix_key('0)) begin
        step_d = step_t'(1);  // mismatch that is itself a valid first entry
      end else begin
        step_d = '0;          // includes KEY_TEST
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q       <= '0;
      store_req_o  <= 1'b0;
      recall_req_o <= 1'b0;
    end else begin
      step_q       <= step_d;
      store_req_o  <= store_d;
      recall_req_o <= recall_d;
    end
  end

  p_req_exclusive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_req_o, recall_req_o}));
  p_store_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |=> !store_req_o);
  p_recall_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |=> !recall_req_o);
  p_req_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_req_o || recall_req_o) |-> step_q == '0);
  p_busy_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(store_req_o || recall_req_o));
  p_busy_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(step_q));
  p_write_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && !is_read_i && !busy_i) |=> step_q == '0);
endmodule

// File: rtl/nv_cmd_detect.sv
module nv_cmd_detect
  import nv_cmd_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              store_req_o,
  output logic              recall_req_o
);
  localparam int SW = KEY_W + 2;

  logic [SW-1:0] pins_s;
  logic          access, is_read;
  logic          unused_hi;

  // R4: bits above the key width never enter the comparison
  assign unused_hi = ^addr_i[ADDR_W-1:KEY_W];

  nv_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({2'b11, {KEY_W{1'b0}}})) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ce_ni, we_ni, addr_i[KEY_W-1:0]}),
    .q_o    (pins_s)
  );

  nv_access_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ns_i   (pins_s[SW-1]),
    .we_ns_i   (pins_s[SW-2]),
    .access_o  (access),
    .is_read_o (is_read)
  );

  nv_seq_track u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .access_i     (access),
    .is_read_i    (is_read),
    .key_i        (pins_s[KEY_W-1:0]),
    .busy_i       (busy_i),
    .store_req_o  (store_req_o),
    .recall_req_o (recall_req_o)
  );
endmodule

// File: tb/tb_nv_cmd_detect.sv
`timescale 1ns/1ps
module tb_nv_cmd_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [14:0] addr = '0;
  logic        st, rc;

  typedef struct { int due; bit st; bit rc; string tag; } exp_t;
  exp_t exp_q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  localparam logic [14:0] A1 = 15'h0E38, A2 = 15'h31C7, A3 = 15'h03E0,
                          A4 = 15'h3C1F, A5 = 15'h303F;
  localparam logic [14:0] K_ST = 15'h0FC0, K_RC = 15'h0C63, K_TEST = 15'h339C;

  always #2.5 clk = ~clk;

  nv_cmd_detect dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n),
    .addr_i(addr), .busy_i(busy), .store_req_o(st), .recall_req_o(rc)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: result due three rising edges after enable falls
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (st !== e.st || rc !== e.rc) begin
          errors++;
          $display("FAIL %s: store/recall=%b%b expected %b%b at cycle %0d",
                   e.tag, st, rc, e.st, e.rc, cyc);
        end
      end else if (st !== 1'b0 || rc !== 1'b0) begin
        checks++;
        errors++;
        $display("FAIL R10: unexpected store/recall=%b%b expected 00 at cycle %0d", st, rc, cyc);
      end
    end
  end

  task automatic access(input logic [14:0] a, input bit wr, input bit e_st,
                        input bit e_rc, input string tag,
                        input bit move = 0, input logic [14:0] a2 = '0);
    exp_t e;
    @(posedge clk); #1;
    addr = a; we_n = ~wr;
    @(posedge clk); #1;
    ce_n = 1'b0;
    e.due = cyc + 3; e.st = e_st; e.rc = e_rc; e.tag = tag;
    exp_q.push_back(e);
    repeat (2) @(posedge clk);
    #1;
    if (move) begin
      addr = a2;
      repeat (3) @(posedge clk);
      #1;
    end
    ce_n = 1'b1; we_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic rd(input logic [14:0] a, input string tag);
    access(a, 0, 0, 0, tag);
  endtask

  task automatic prefix(input string tag);
    rd(A1, tag); rd(A2, tag); rd(A3, tag); rd(A4, tag); rd(A5, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (st !== 1'b0 || rc !== 1'b0) begin
      errors++;
      $display("FAIL R10: reset store/recall=%b%b expected 00", st, rc);
    end

    // R1 store, then a lone repeat of the sixth address does nothing
    prefix("R1"); access(K_ST, 0, 1, 0, "R1");
    rd(K_ST, "R1");
    // R2 recall
    prefix("R2"); access(K_RC, 0, 0, 1, "R2");
    // R3 reserved code, then store code alone does nothing
    prefix("R3"); rd(K_TEST, "R3"); rd(K_ST, "R3");
    // R4 bit 14 set everywhere
    rd(A1 | 15'h4000, "R4"); rd(A2 | 15'h4000, "R4"); rd(A3 | 15'h4000, "R4");
    rd(A4 | 15'h4000, "R4"); rd(A5 | 15'h4000, "R4");
    access(K_ST | 15'h4000, 0, 1, 0, "R4");
    // R5 address change while enable held low is not an access
    access(A1, 0, 0, 0, "R5", 1, A2);
    rd(A3, "R5"); rd(A4, "R5"); rd(A5, "R5"); rd(K_ST, "R5");
    // R6 write at the expected address aborts
    rd(A1, "R6"); rd(A2, "R6"); rd(A3, "R6");
    access(A4, 1, 0, 0, "R6");
    rd(A4, "R6"); rd(A5, "R6"); rd(K_ST, "R6");
    // R7 repeated read aborts; plain mismatch aborts
    rd(A1, "R7"); rd(A2, "R7"); rd(A2, "R7");
    rd(A3, "R7"); rd(A4, "R7"); rd(A5, "R7"); rd(K_ST, "R7");
    rd(A1, "R7"); rd(15'h1234, "R7"); rd(A2, "R7"); rd(A3, "R7");
    rd(A4, "R7"); rd(A5, "R7"); rd(K_RC, "R7");
    // R8 mismatch at first prefix address restarts at step two
    rd(A1, "R8"); rd(A2, "R8"); rd(A1, "R8");
    prefix("R8");
    rd(A1, "R8"); rd(A2, "R8"); rd(A1, "R8");
    rd(A2, "R8"); rd(A3, "R8"); rd(A4, "R8"); rd(A5, "R8");
    access(K_ST, 0, 1, 0, "R8");
    // R9 busy: sixth read and a write ignored, progress kept
    prefix("R9");
    @(posedge clk); #1 busy = 1'b1;
    rd(K_ST, "R9");
    access(A1, 1, 0, 0, "R9");
    @(posedge clk); #1 busy = 1'b0;
    access(K_RC, 0, 0, 1, "R9");

    repeat (8) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R10: %0d results never observed, expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule